// File: doc/BRIEF.md
# Watchdog timer with reset pulse

A memory-mapped watchdog that counts down from a power-of-two timeout and, unless software restarts it in time, asserts a system reset pulse of programmable length. A control register holds a sticky enable bit, a response-mode bit and a 3-bit pulse-length field. A range register holds two timeout selectors: one for the first load after enabling and one for every later reload. Software restarts the count by writing a fixed kick word. It can read the live count and an interrupt status bit.

In mode 0 the block resets as soon as the count expires. In mode 1 the first expiry raises an interrupt and reloads the count. A second expiry, with that interrupt still pending, issues the reset pulse. Every control field reads back as it was written, so software can do a read-modify-write without disturbing the pulse length. The bus is a single-cycle bus: a write takes effect at the clock edge where `req_i` and `we_i` are high, and read data is combinational from `addr_i` in the same cycle.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the control register (offset 0x00) reads 0x08 (enable 0, mode 0, pulse field 010). The range (0x04), count (0x08) and status (0x10) registers read 0. `sys_rst_o` and `irq_o` are low.
- R2: Control bit 0 is enable, bit 1 is response mode and bits [4:2] are the pulse field. Bits [4:1] read back exactly as last written, and all upper bits read 0. Once set, enable stays 1 until reset, whatever is written.
- R3: A control write with bit 0 set while disabled loads the count with 2^(BASE_EXP+i)-1, where i is range bits [7:4]. The count then drops by one each cycle and reads back at 0x08.
- R4: While enabled, writing exactly 0x76 to offset 0x0C reloads the count with 2^(BASE_EXP+t)-1, where t is range bits [3:0], and clears the interrupt. Any other value, and any write while disabled, leaves the count untouched.
- R5: In mode 0, the edge at which the count is 0 is an expiry. From the next cycle `sys_rst_o` is high, no interrupt is raised, and the count is reloaded from range bits [3:0].
- R6: The reset pulse lasts 2^(n+1) cycles, where n is the pulse field at the moment of expiry. This gives 8 cycles by default and 256 cycles for n=7.
- R7: In mode 1, an expiry with no interrupt pending sets the interrupt (`irq_o`, status bit 0) and reloads the count without any reset. An expiry with the interrupt pending issues the reset pulse.
- R8: A kick in the same cycle that the count is 0 wins. The count reloads and no expiry happens.
- R9: The range register reads back bits [7:0] as written. Writes to the count register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, combinational from addr_i |
| irq_o | output | 1 | Pending interrupt from a first expiry in mode 1 |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
A kick and an expiry can fall on the same clock edge. The bench provokes this by counting cycles from the enable write, so that the restart write lands exactly on the edge where the count reads 0. It then judges the result at the ports: the reset output must stay low, and the count read one cycle later must be one below the full reload value. Any expiry would instead have raised the reset on the following cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int OFS_CTRL    = 'h00;
  localparam int OFS_RANGE   = 'h04;
  localparam int OFS_COUNT   = 'h08;
  localparam int OFS_RESTART = 'h0C;
  localparam int OFS_STATUS  = 'h10;
  localparam int KICK_WORD   = 'h76;
  localparam int TOP_W       = 4;
  localparam int PLEN_W      = 3;
  localparam logic [PLEN_W-1:0] PLEN_RST = 3'b010;

  typedef struct packed {
    logic [PLEN_W-1:0] plen;
    logic              mode;
    logic              en;
  } ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              irq_i,
  output logic [DATA_W-1:0] rdata_o,
  output ctrl_t             ctrl_o,
  output logic [TOP_W-1:0]  top_o,
  output logic [TOP_W-1:0]  top_init_o,
  output logic              en_set_o,
  output logic              kick_o
);
  ctrl_t            ctrl_q;
  logic [TOP_W-1:0] top_q, init_q;
  logic             wr, wr_ctrl, wr_range, wr_rst;

  assign wr       = req_i & we_i;
  assign wr_ctrl  = wr & (addr_i == ADDR_W'(OFS_CTRL));
  assign wr_range = wr & (addr_i == ADDR_W'(OFS_RANGE));
  assign wr_rst   = wr & (addr_i == ADDR_W'(OFS_RESTART));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '{plen: PLEN_RST, mode: 1'b0, en: 1'b0};
      top_q  <= '0;
      init_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.en   <= ctrl_q.en | wdata_i[0];  // enable is sticky
        ctrl_q.mode <= wdata_i[1];
        ctrl_q.plen <= wdata_i[2+:PLEN_W];
      end
      if (wr_range) begin
        top_q  <= wdata_i[0+:TOP_W];
        init_q <= wdata_i[TOP_W+:TOP_W];
      end
    end
  end

  assign en_set_o   = wr_ctrl & wdata_i[0] & ~ctrl_q.en;
  assign kick_o     = wr_rst & ctrl_q.en & (wdata_i == DATA_W'(KICK_WORD));
  assign ctrl_o     = ctrl_q;
  assign top_o      = top_q;
  assign top_init_o = init_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(OFS_CTRL):   rdata_o = DATA_W'(ctrl_q);
      ADDR_W'(OFS_RANGE):  rdata_o = DATA_W'({init_q, top_q});
      ADDR_W'(OFS_COUNT):  rdata_o = DATA_W'(count_i);
      ADDR_W'(OFS_STATUS): rdata_o = DATA_W'(irq_i);
      default:             rdata_o = '0;
    endcase
  end

  assert_en_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.en |=> ctrl_q.en);
  assert_plen_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ctrl |=> $stable(ctrl_q.plen) && $stable(ctrl_q.mode));
  assert_range_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_range |=> $stable(top_q) && $stable(init_q));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int BASE_EXP = 16,
  parameter int CNT_W    = BASE_EXP + 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_init_i,
  input  logic             kick_i,
  input  logic [TOP_W-1:0] top_i,
  input  logic [TOP_W-1:0] top_init_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] period_m1(input logic [TOP_W-1:0] t);
    return (CNT_W'(1) << (BASE_EXP + 32'(t))) - CNT_W'(1);
  endfunction

  // kick has priority over expiry
  assign expire_o = en_i & ~kick_i & ~load_init_i & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_init_i)       cnt_q <= period_m1(top_init_i);
    else if (en_i) begin
      if (kick_i || cnt_q == '0) cnt_q <= period_m1(top_i);
      else                       cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign count_o = cnt_q;

  assert_kick_blocks_expiry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kick_i && en_i) |=> !expire_o);
  assert_frozen_when_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_init_i) |=> $stable(count_o));
  assert_expiry_reloads_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> count_o != '0);
endmodule

// File: rtl/wdog_resp.sv
module wdog_resp
  import wdog_pkg::*;
#(
  parameter int PCNT_W = (1 << PLEN_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              expire_i,
  input  logic              kick_i,
  input  logic              mode_i,
  input  logic [PLEN_W-1:0] plen_i,
  output logic              irq_o,
  output logic              rst_o
);
  logic              irq_q;
  logic [PCNT_W-1:0] pcnt_q;
  logic              to_irq;

  assign to_irq = expire_i & mode_i & ~irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      pcnt_q <= '0;
    end else begin
      if (to_irq)      irq_q <= 1'b1;
      else if (kick_i) irq_q <= 1'b0;

      if (expire_i && !to_irq) pcnt_q <= PCNT_W'(1) << (32'(plen_i) + 1);
      else if (pcnt_q != '0)   pcnt_q <= pcnt_q - PCNT_W'(1);
    end
  end

  assign irq_o = irq_q;
  assign rst_o = (pcnt_q != '0);

  assert_mode0_resets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && !mode_i) |=> rst_o && !$rose(irq_o));
  assert_pulse_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_o) |-> $past(expire_i));
  assert_irq_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(expire_i && mode_i));
  assert_first_expiry_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && mode_i && !irq_o && !rst_o) |=> !rst_o);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 32,
  parameter int BASE_EXP = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              sys_rst_o
);
  localparam int CNT_W = BASE_EXP + (1 << TOP_W);

  ctrl_t            ctrl;
  logic [TOP_W-1:0] top, top_init;
  logic             en_set, kick, expire, irq;
  logic [CNT_W-1:0] count;

  wdog_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .count_i(count), .irq_i(irq), .rdata_o,
    .ctrl_o(ctrl), .top_o(top), .top_init_o(top_init),
    .en_set_o(en_set), .kick_o(kick)
  );

  wdog_counter #(.BASE_EXP(BASE_EXP), .CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .en_i(ctrl.en), .load_init_i(en_set), .kick_i(kick),
    .top_i(top), .top_init_i(top_init), .count_o(count), .expire_o(expire)
  );

  wdog_resp u_resp (
    .clk_i, .rst_ni, .expire_i(expire), .kick_i(kick), .mode_i(ctrl.mode),
    .plen_i(ctrl.plen), .irq_o(irq), .rst_o(sys_rst_o)
  );

  assign irq_o = irq;
endmodule

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;
  localparam int BASE_EXP = 2;
  localparam logic [4:0] A_CTRL = 5'h00, A_RANGE = 5'h04, A_COUNT = 5'h08,
                         A_RESTART = 5'h0C, A_STATUS = 5'h10;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, req = 1'b0, we = 1'b0, probe = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0, rdata;
  logic irq, sys_rst;

  wdog_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_EXP(BASE_EXP)) u_wdog_timer (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .sys_rst_o(sys_rst)
  );

  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;  // kind 0 rdata, 1 reset, 2 irq
  item_t sb_q[$];
  int n_chk = 0, n_bad = 0, slot = 0;

  task automatic drive(input logic r, input logic w, input logic [ADDR_W-1:0] a,
                       input logic [DATA_W-1:0] d, input logic p);
    @(posedge clk); #1;
    req = r; we = w; addr = a; wdata = d; probe = p; slot++;
  endtask
  task automatic idle(); drive(1'b0, 1'b0, '0, '0, 1'b0); endtask
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    drive(1'b1, 1'b1, a, d, 1'b0);
  endtask
  task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string t);
    sb_q.push_back('{0, e, t});
    drive(1'b1, 1'b0, a, '0, 1'b1);
  endtask
  task automatic smp(input int k, input logic e, input string t);
    sb_q.push_back('{k, 32'(e), t});
    drive(1'b0, 1'b0, '0, '0, 1'b1);
  endtask
  task automatic go(input int j); while (slot < j - 1) idle(); endtask
  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0; req = 1'b0; we = 1'b0; probe = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  // monitor: pops the scoreboard away from the active edge
  always @(negedge clk) begin
    if (probe && rst_n) begin
      item_t it;
      logic [31:0] act;
      if (sb_q.size() == 0) begin
        n_bad++; $display("FAIL scoreboard underflow: act 0 exp 1");
      end else begin
        it = sb_q.pop_front();
        act = (it.kind == 0) ? rdata : (it.kind == 1) ? 32'(sys_rst) : 32'(irq);
        n_chk++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: act 0x%0h exp 0x%0h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: act hung exp done");
    finish_run();
  end

  initial begin
    // R1 reset state, R4 kick ignored while disabled, R9 range readback
    do_reset();
    rd(A_CTRL, 32'h08, "R1 ctrl");
    rd(A_RANGE, 0, "R1 range");
    rd(A_COUNT, 0, "R1 count");
    rd(A_STATUS, 0, "R1 status");
    smp(1, 1'b0, "R1 sys_rst");
    smp(2, 1'b0, "R1 irq");
    wr(A_RESTART, 32'h76);
    rd(A_COUNT, 0, "R4 kick while disabled");
    wr(A_RANGE, 32'h21);
    rd(A_RANGE, 32'h21, "R9 range");
    wr(A_CTRL, 32'h05); slot = 0;            // init 16 cycles, pulse 4
    rd(A_COUNT, 15, "R3 first load");
    rd(A_COUNT, 14, "R3 decrement");
    rd(A_CTRL, 32'h05, "R2 readback");
    wr(A_COUNT, 32'h0);
    rd(A_COUNT, 11, "R9 count write ignored");
    wr(A_RESTART, 32'h12);
    rd(A_COUNT, 9, "R4 wrong kick ignored");
    wr(A_RESTART, 32'h76); slot = 0;         // top period 8
    rd(A_COUNT, 7, "R4 kick reload");
    go(8);  smp(1, 1'b0, "R5 before expiry");
    rd(A_COUNT, 7, "R5 reload on expiry");
    smp(1, 1'b1, "R5 reset asserted");
    go(12); smp(1, 1'b1, "R6 pulse last cycle");
    smp(1, 1'b0, "R6 pulse ended");
    smp(2, 1'b0, "R5 no interrupt");
    wr(A_CTRL, 32'h1C);
    rd(A_CTRL, 32'h1D, "R2 enable sticky");

    // R6 default 8-cycle pulse
    do_reset();
    wr(A_RANGE, 32'h33);
    wr(A_CTRL, 32'h09); slot = 0;            // period 32
    go(32); smp(1, 1'b0, "R6 default pre");
    smp(1, 1'b1, "R6 default first");
    go(40); smp(1, 1'b1, "R6 default last");
    smp(1, 1'b0, "R6 default end");

    // R6 longest pulse
    do_reset();
    wr(A_RANGE, 32'h77);
    wr(A_CTRL, 32'h1D); slot = 0;            // period 512
    go(512); smp(1, 1'b0, "R6 max pre");
    smp(1, 1'b1, "R6 max first");
    go(768); smp(1, 1'b1, "R6 max last");
    smp(1, 1'b0, "R6 max end");

    // R7 interrupt then reset
    do_reset();
    wr(A_RANGE, 32'h22);
    wr(A_CTRL, 32'h03); slot = 0;            // period 16, pulse 2
    go(16); smp(2, 1'b0, "R7 irq before");
    smp(2, 1'b1, "R7 irq set");
    rd(A_STATUS, 1, "R7 status");
    smp(1, 1'b0, "R7 no reset on first");
    go(32); smp(1, 1'b0, "R7 before second");
    smp(1, 1'b1, "R7 reset on second");
    smp(1, 1'b1, "R7 pulse cycle 2");
    smp(1, 1'b0, "R7 pulse end");
    smp(2, 1'b1, "R7 irq held");
    wr(A_RESTART, 32'h76);
    smp(2, 1'b0, "R4 kick clears irq");

    // R8 kick on the expiry edge
    do_reset();
    wr(A_RANGE, 32'h11);
    wr(A_CTRL, 32'h01); slot = 0;            // period 8
    go(7); rd(A_COUNT, 1, "R8 count before");
    wr(A_RESTART, 32'h76);
    smp(1, 1'b0, "R8 no reset");
    rd(A_COUNT, 6, "R8 reload");
    smp(2, 1'b0, "R8 no irq");

    idle(); idle();
    if (sb_q.size() != 0) begin
      n_bad++; $display("FAIL scoreboard leftover: act %0d exp 0", sb_q.size());
    end
    finish_run();
  end
endmodule